// File: doc/BRIEF.md
# I2C Slave Address Matcher (7-bit, 10-bit, General Call)

This block sits behind the byte deserializer of an I2C slave. It watches the address bytes that follow each START or repeated START and decides, byte by byte, whether the slave should pull SDA low in the acknowledge slot. The own address is either 7 or 10 bits wide, chosen by a mode input. Recognition of the general call address can be switched on or off. The block reports whether the slave is addressed, whether the slave will transmit (master read), and whether a general call is in progress. Bit timing, the shift register and the handling of data contents are left to neighbouring logic.

In 10-bit mode the block remembers a completed two-byte write-addressing sequence across a repeated START. A later header byte carrying only the two high address bits and a read flag then selects the slave as transmitter on its own. A fresh START or a STOP ends that memory. Every decision is registered. It appears on the clock after the byte is presented and stays in place until the next byte or bus condition, which leaves it ready for the ninth SCL pulse.

Top module: `i2c_addr_matcher`

## Requirements
- R1: With `ten_bit_mode_i`=0, a first byte whose bits [7:1] equal `own_addr_i[6:0]` gives `ack_o`=1, `matched_o`=1 and `slave_tx_o`=byte bit 0 on the cycle after `byte_valid_i`.
- R2: A first byte that does not match the own address gives `ack_o`=0 and leaves `matched_o` low. A byte 11110xxx never matches in 7-bit mode.
- R3: With `ten_bit_mode_i`=1, a first byte 11110,`own_addr_i[9:8]`,0 is acknowledged without raising `matched_o`. A following byte equal to `own_addr_i[7:0]` is acknowledged and raises `matched_o` with `slave_tx_o`=0.
- R4: A mismatching second 10-bit byte gives `ack_o`=0, keeps `matched_o` low and cancels any remembered 10-bit selection.
- R5: After a completed 10-bit match and then a repeated START, a byte 11110,`own_addr_i[9:8]`,1 is acknowledged and sets `matched_o`=1 and `slave_tx_o`=1. The same byte is refused when no 10-bit selection is remembered (after STOP, a fresh START, a failed second byte or any other first byte).
- R6: A first byte 0x00 is acknowledged and sets `gcall_o` only while `gcall_en_i`=1. Later bytes are then acknowledged while the enable stays high. Clearing the enable drops `gcall_o` on the next cycle, and later bytes are refused.
- R7: A STOP, START or repeated START ends a general call: `gcall_o` goes low on the next cycle.
- R8: First bytes 0x01 to 0x07 and 0xF8 to 0xFF are never acknowledged and raise no flag.
- R9: After reset, `ack_o`, `matched_o`, `slave_tx_o` and `gcall_o` are 0. `ack_o` changes only on the cycle after a byte, START, repeated START or STOP.
- R10: Once the slave is addressed, each later byte gives `ack_o`=1 if `slave_tx_o`=0 and `ack_o`=0 if `slave_tx_o`=1. Bytes that arrive while the slave is not addressed give `ack_o`=0.
- R11: STOP clears `matched_o` and `slave_tx_o` and forgets the 10-bit selection. START and repeated START clear `matched_o`, `slave_tx_o` and `ack_o`. A repeated START keeps the 10-bit selection, while a fresh START forgets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: START after bus idle |
| rstart_i | input | 1 | One-cycle pulse: repeated START |
| stop_i | input | 1 | One-cycle pulse: STOP |
| byte_valid_i | input | 1 | One-cycle pulse: `rx_byte_i` holds a complete byte |
| rx_byte_i | input | 8 | Received byte, MSB first on the wire |
| ten_bit_mode_i | input | 1 | 0: 7-bit own address, 1: 10-bit own address |
| own_addr_i | input | 10 | Own address; bits [6:0] are used in 7-bit mode |
| gcall_en_i | input | 1 | Enables general call recognition |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| matched_o | output | 1 | Own address fully matched |
| slave_tx_o | output | 1 | Slave is transmitter (master read) |
| gcall_o | output | 1 | General call reception in progress |

## Verification
A wrong phase register shows up on the first byte after a bus condition. An address byte taken as data, or data taken as an address, turns `ack_o` around on the very next cycle. A stale or lost 10-bit selection stays hidden until a later repeated-START read header. It is seen as a wrong `ack_o` and a wrong `matched_o` one cycle after that header. For this reason the stimulus mixes full write sequences, failed second bytes, STOPs and fresh STARTs ahead of read headers. A general call flag that stays set shows as a wrong `gcall_o` one cycle after the enable falls or a bus condition arrives.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

    localparam int BYTE_W  = 8;
    localparam int OWN_W   = 10;
    localparam int HI_W    = OWN_W - BYTE_W;
    localparam int ADDR7_W = BYTE_W - 1;
    localparam int HDR_W   = BYTE_W - HI_W - 1;
    localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;
    localparam logic [HDR_W-1:0] RSV_HI  = 5'b11111;
    localparam logic [HDR_W-1:0] RSV_LO  = 5'b00000;

    typedef enum logic [1:0] {
        FK_GCALL,
        FK_RESERVED,
        FK_TEN_HDR,
        FK_SEVEN
    } first_kind_e;

    typedef struct packed {
        first_kind_e          kind;
        logic                 rw;
        logic [HI_W-1:0]      hi;
        logic [ADDR7_W-1:0]   addr7;
    } first_info_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR1,
        PH_ADDR2,
        PH_OWN,
        PH_GCALL
    } phase_e;

    function automatic logic is_reserved_first(input logic [BYTE_W-1:0] b);
        return ((b[BYTE_W-1 -: HDR_W] == RSV_LO) && (b != '0)) ||
               (b[BYTE_W-1 -: HDR_W] == RSV_HI);
    endfunction

    function automatic first_info_t decode_first(input logic [BYTE_W-1:0] b);
        first_info_t r;
        r.rw    = b[0];
        r.hi    = b[HI_W:1];
        r.addr7 = b[BYTE_W-1:1];
        if (b == '0)
            r.kind = FK_GCALL;
        else if (is_reserved_first(b))
            r.kind = FK_RESERVED;
        else if (b[BYTE_W-1 -: HDR_W] == TEN_HDR)
            r.kind = FK_TEN_HDR;
        else
            r.kind = FK_SEVEN;
        return r;
    endfunction

endpackage

// File: rtl/first_byte_classifier.sv
module first_byte_classifier
    import i2c_addr_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output first_info_t       info_o
);
    always_comb info_o = decode_first(byte_i);
endmodule

// File: rtl/ten_bit_tracker.sv
module ten_bit_tracker (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic sel_o
);
    always_ff @(posedge clk) begin
        if (rst)        sel_o <= 1'b0;
        else if (clr_i) sel_o <= 1'b0;
        else if (set_i) sel_o <= 1'b1;
    end
endmodule

// File: rtl/addr_phase_ctrl.sv
module addr_phase_ctrl
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rstart_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  first_info_t       info_i,
    input  logic              ten_bit_mode_i,
    input  logic [OWN_W-1:0]  own_addr_i,
    input  logic              gcall_en_i,
    input  logic              sel10_i,
    output phase_e            phase_o,
    output logic              ack_o,
    output logic              matched_o,
    output logic              slave_tx_o,
    output logic              gcall_o,
    output logic              sel_set_o,
    output logic              sel_clr_o
);
    phase_e ph_d;
    logic   ack_d, mat_d, tx_d, gc_d;
    logic   hi_ok, seven_ok, low_ok;

    always_comb begin
        hi_ok    = ten_bit_mode_i && (info_i.hi == own_addr_i[OWN_W-1 -: HI_W]);
        seven_ok = !ten_bit_mode_i && (info_i.addr7 == own_addr_i[ADDR7_W-1:0]);
        low_ok   = (rx_byte_i == own_addr_i[BYTE_W-1:0]);
    end

    always_comb begin
        ph_d      = phase_o;
        ack_d     = ack_o;
        mat_d     = matched_o;
        tx_d      = slave_tx_o;
        gc_d      = gcall_o;
        sel_set_o = 1'b0;
        sel_clr_o = 1'b0;
        if (stop_i) begin
            ph_d  = PH_IDLE;
            ack_d = 1'b0;
            mat_d = 1'b0;
            tx_d  = 1'b0;
            gc_d  = 1'b0;
        end else if (start_i || rstart_i) begin
            ph_d  = PH_ADDR1;
            ack_d = 1'b0;
            mat_d = 1'b0;
            tx_d  = 1'b0;
            gc_d  = 1'b0;
        end else begin
            if ((phase_o == PH_GCALL) && !gcall_en_i) begin
                ph_d = PH_IDLE;
                gc_d = 1'b0;
            end
            if (byte_valid_i) begin
                case (phase_o)
                    PH_ADDR1: begin
                        ack_d     = 1'b0;
                        ph_d      = PH_IDLE;
                        sel_clr_o = 1'b1;
                        case (info_i.kind)
                            FK_GCALL: begin
                                if (gcall_en_i) begin
                                    ack_d = 1'b1;
                                    gc_d  = 1'b1;
                                    ph_d  = PH_GCALL;
                                end
                            end
                            FK_TEN_HDR: begin
                                if (hi_ok && !info_i.rw) begin
                                    ack_d     = 1'b1;
                                    ph_d      = PH_ADDR2;
                                    sel_clr_o = 1'b0;
                                end else if (hi_ok && sel10_i) begin
                                    ack_d     = 1'b1;
                                    mat_d     = 1'b1;
                                    tx_d      = 1'b1;
                                    ph_d      = PH_OWN;
                                    sel_clr_o = 1'b0;
                                end
                            end
                            FK_SEVEN: begin
                                if (seven_ok) begin
                                    ack_d = 1'b1;
                                    mat_d = 1'b1;
                                    tx_d  = info_i.rw;
                                    ph_d  = PH_OWN;
                                end
                            end
                            default: ack_d = 1'b0;
                        endcase
                    end
                    PH_ADDR2: begin
                        if (low_ok) begin
                            ack_d     = 1'b1;
                            mat_d     = 1'b1;
                            tx_d      = 1'b0;
                            ph_d      = PH_OWN;
                            sel_set_o = 1'b1;
                        end else begin
                            ack_d     = 1'b0;
                            ph_d      = PH_IDLE;
                            sel_clr_o = 1'b1;
                        end
                    end
                    PH_OWN:   ack_d = !slave_tx_o;
                    PH_GCALL: ack_d = gcall_en_i;
                    default:  ack_d = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o    <= PH_IDLE;
            ack_o      <= 1'b0;
            matched_o  <= 1'b0;
            slave_tx_o <= 1'b0;
            gcall_o    <= 1'b0;
        end else begin
            phase_o    <= ph_d;
            ack_o      <= ack_d;
            matched_o  <= mat_d;
            slave_tx_o <= tx_d;
            gcall_o    <= gc_d;
        end
    end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rstart_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              ten_bit_mode_i,
    input  logic [OWN_W-1:0]  own_addr_i,
    input  logic              gcall_en_i,
    output logic              ack_o,
    output logic              matched_o,
    output logic              slave_tx_o,
    output logic              gcall_o
);
    first_info_t info;
    phase_e      phase_q;
    logic        sel10_q, sel_set, sel_clr, tracker_clr;

    first_byte_classifier u_cls (
        .byte_i (rx_byte_i),
        .info_o (info)
    );

    always_comb tracker_clr = stop_i || start_i || (sel_clr && !rstart_i);

    ten_bit_tracker u_sel (
        .clk   (clk),
        .rst   (rst),
        .set_i (sel_set && !rstart_i),
        .clr_i (tracker_clr),
        .sel_o (sel10_q)
    );

    addr_phase_ctrl u_ctl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .rstart_i       (rstart_i),
        .stop_i         (stop_i),
        .byte_valid_i   (byte_valid_i),
        .rx_byte_i      (rx_byte_i),
        .info_i         (info),
        .ten_bit_mode_i (ten_bit_mode_i),
        .own_addr_i     (own_addr_i),
        .gcall_en_i     (gcall_en_i),
        .sel10_i        (sel10_q),
        .phase_o        (phase_q),
        .ack_o          (ack_o),
        .matched_o      (matched_o),
        .slave_tx_o     (slave_tx_o),
        .gcall_o        (gcall_o),
        .sel_set_o      (sel_set),
        .sel_clr_o      (sel_clr)
    );
endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk
    import i2c_addr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              rstart_i,
    input logic              stop_i,
    input logic              byte_valid_i,
    input logic [BYTE_W-1:0] rx_byte_i,
    input logic              gcall_en_i,
    input logic              ack_o,
    input logic              matched_o,
    input logic              slave_tx_o,
    input logic              gcall_o,
    input phase_e            phase_q,
    input logic              sel10_q
);
    logic bus_evt;
    always_comb bus_evt = start_i || rstart_i || stop_i;

    // R11
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (!matched_o && !slave_tx_o && !gcall_o && !sel10_q));

    // R6
    gc_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !gcall_en_i |=> !gcall_o);

    // R7
    gc_end_chk: assert property (@(posedge clk) disable iff (rst)
        bus_evt |=> !gcall_o);

    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid_i && !bus_evt) |=> $stable(ack_o));

    // R8
    reserved_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_i && !bus_evt && phase_q == PH_ADDR1 && is_reserved_first(rx_byte_i))
        |=> (!ack_o && !matched_o && !gcall_o));

    // R5
    tenrd_unsel_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_i && !bus_evt && phase_q == PH_ADDR1 &&
         rx_byte_i[BYTE_W-1 -: HDR_W] == TEN_HDR && rx_byte_i[0] && !sel10_q)
        |=> (!ack_o && !matched_o));

    // R3
    half_ten_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ADDR2) |-> !matched_o);

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({matched_o, gcall_o}));
endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .rstart_i     (rstart_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .rx_byte_i    (rx_byte_i),
    .gcall_en_i   (gcall_en_i),
    .ack_o        (ack_o),
    .matched_o    (matched_o),
    .slave_tx_o   (slave_tx_o),
    .gcall_o      (gcall_o),
    .phase_q      (phase_q),
    .sel10_q      (sel10_q)
);

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, rstart_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic       ten_bit_mode_i = 1'b0;
    logic [9:0] own_addr_i = 10'h000;
    logic       gcall_en_i = 1'b0;
    logic       ack_o, matched_o, slave_tx_o, gcall_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state: 0 idle, 1 addr1, 2 addr2, 3 own, 4 gcall
    int    mph = 0;
    bit    msel = 0, mack = 0, mmat = 0, mtx = 0, mgc = 0;
    string mtag = "R9";

    always #10 clk = ~clk;

    i2c_addr_matcher uut (
        .clk(clk), .rst(rst), .start_i(start_i), .rstart_i(rstart_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .rx_byte_i(rx_byte_i), .ten_bit_mode_i(ten_bit_mode_i),
        .own_addr_i(own_addr_i), .gcall_en_i(gcall_en_i), .ack_o(ack_o),
        .matched_o(matched_o), .slave_tx_o(slave_tx_o), .gcall_o(gcall_o)
    );

    function automatic bit rsv(input logic [7:0] b);
        return (b >= 8'h01 && b <= 8'h07) || (b >= 8'hF8);
    endfunction

    task automatic cmp(input string tag, input string what, input logic act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "ack_o", ack_o, mack);
        cmp(tag, "matched_o", matched_o, mmat);
        cmp(tag, "slave_tx_o", slave_tx_o, mtx);
        cmp(tag, "gcall_o", gcall_o, mgc);
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (mph)
            1: begin
                mack = 0; mph = 0;
                if (b == 8'h00) begin
                    mtag = "R6"; msel = 0;
                    if (gcall_en_i) begin mack = 1; mgc = 1; mph = 4; end
                end else if (rsv(b)) begin
                    mtag = "R8"; msel = 0;
                end else if (b[7:3] == 5'b11110) begin
                    if (ten_bit_mode_i && b[2:1] == own_addr_i[9:8] && !b[0]) begin
                        mtag = "R3"; mack = 1; mph = 2;
                    end else if (ten_bit_mode_i && b[2:1] == own_addr_i[9:8] && msel) begin
                        mtag = "R5"; mack = 1; mmat = 1; mtx = 1; mph = 3;
                    end else begin
                        mtag = b[0] ? "R5" : "R2"; msel = 0;
                    end
                end else if (!ten_bit_mode_i && b[7:1] == own_addr_i[6:0]) begin
                    mtag = "R1"; msel = 0; mack = 1; mmat = 1; mtx = b[0]; mph = 3;
                end else begin
                    mtag = "R2"; msel = 0;
                end
            end
            2: begin
                if (b == own_addr_i[7:0]) begin
                    mtag = "R3"; mack = 1; mmat = 1; mtx = 0; msel = 1; mph = 3;
                end else begin
                    mtag = "R4"; mack = 0; msel = 0; mph = 0;
                end
            end
            3: begin mtag = "R10"; mack = !mtx; end
            4: begin mtag = "R6"; mack = gcall_en_i; end
            default: begin mtag = "R10"; mack = 0; end
        endcase
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        model_byte(b);
        rx_byte_i = b; byte_valid_i = 1'b1;
        @(negedge clk);
        byte_valid_i = 1'b0;
        check_all(mtag);
    endtask

    task automatic bus_start(input bit repeated);
        @(negedge clk);
        if (repeated) rstart_i = 1'b1; else begin start_i = 1'b1; msel = 0; end
        mph = 1; mack = 0; mmat = 0; mtx = 0; mgc = 0;
        @(negedge clk);
        start_i = 1'b0; rstart_i = 1'b0;
        check_all(repeated ? "R7" : "R11");
    endtask

    task automatic bus_stop();
        @(negedge clk);
        stop_i = 1'b1;
        mph = 0; mack = 0; mmat = 0; mtx = 0; mgc = 0; msel = 0;
        @(negedge clk);
        stop_i = 1'b0;
        check_all("R11");
    endtask

    task automatic set_gc(input bit v);
        @(negedge clk);
        gcall_en_i = v;
        if (!v && mph == 4) begin mph = 0; mgc = 0; end
        @(negedge clk);
        check_all("R6");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unused;
        unused = $urandom(32'h1C2A_0B17);
        own_addr_i = 10'h2A5;   // 7-bit view 0x25, 10-bit hi=2'b10, low=0xA5
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R9");

        // R1 7-bit write then data (R10)
        ten_bit_mode_i = 1'b0; gcall_en_i = 1'b1;
        bus_start(0); send_byte({7'h25, 1'b0}); send_byte(8'h3C); bus_stop();
        // R1 7-bit read, data not acked (R10)
        bus_start(0); send_byte({7'h25, 1'b1}); send_byte(8'h00); bus_stop();
        // R2 mismatch and 10-bit header in 7-bit mode
        bus_start(0); send_byte({7'h26, 1'b0}); send_byte(8'hFF);
        bus_start(1); send_byte(8'hF4); bus_stop();
        // R8 reserved bytes
        for (int i = 1; i < 8; i++) begin bus_start(0); send_byte(i[7:0]); end
        for (int i = 248; i < 256; i++) begin bus_start(1); send_byte(i[7:0]); end
        bus_stop();
        // R6 general call
        bus_start(0); send_byte(8'h00); send_byte(8'h55); set_gc(0); send_byte(8'h66);
        set_gc(1); bus_start(1); send_byte(8'h00); bus_start(1);   // R7
        set_gc(0); send_byte(8'h00); set_gc(1); bus_stop();

        // 10-bit mode
        ten_bit_mode_i = 1'b1;
        // R3 then R5 read via Sr
        bus_start(0); send_byte(8'hF4); send_byte(8'hA5); send_byte(8'h11);
        bus_start(1); send_byte(8'hF5); send_byte(8'h22);
        // R11 repeated Sr keeps selection
        bus_start(1); send_byte(8'hF5); bus_stop();
        // R5 refused after STOP
        bus_start(0); send_byte(8'hF5);
        // R4 bad second byte, then read refused
        bus_start(0); send_byte(8'hF4); send_byte(8'hA4);
        bus_start(1); send_byte(8'hF5);
        // R11 fresh START forgets selection
        bus_start(0); send_byte(8'hF4); send_byte(8'hA5);
        bus_start(0); send_byte(8'hF5);
        // R2 wrong high bits, 7-bit address ignored in 10-bit mode
        bus_start(0); send_byte(8'hF2); bus_start(0); send_byte({7'h25, 1'b0});
        bus_stop();

        // random phase
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = $urandom_range(0, 19);
            if (op < 2) bus_start(0);
            else if (op < 4) bus_start(1);
            else if (op < 5) bus_stop();
            else if (op < 6) set_gc($urandom_range(0, 1) != 0);
            else if (op < 7) begin
                @(negedge clk); ten_bit_mode_i = $urandom_range(0, 1) != 0;
            end else begin
                logic [7:0] b;
                case ($urandom_range(0, 7))
                    0: b = {5'b11110, own_addr_i[9:8], 1'b0};
                    1: b = {5'b11110, own_addr_i[9:8], 1'b1};
                    2: b = own_addr_i[7:0];
                    3: b = {own_addr_i[6:0], 1'($urandom_range(0, 1))};
                    4: b = 8'h00;
                    5: b = 8'($urandom_range(1, 7));
                    default: b = 8'($urandom_range(0, 255));
                endcase
                send_byte(b);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule